// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash device. Some other agent has already sent a program or erase command. The block then decides when that operation has ended, and whether it ended well. A single start pulse latches a target address. The block then issues read cycles to that address through a synchronous request/acknowledge read port. It watches bit 6 of each returned byte, which the device inverts on every read while it is busy, and bit 5, which the device raises when its internal time limit is exceeded.

Reads are taken in pairs. When the toggle bit agrees across a pair, the operation is over. When it disagrees and the error bit of the later read is clear, the block polls again. When it disagrees and the error bit is set, the block takes exactly one more confirming pair, because the device may have finished just as the error bit was sampled. A disagreement in the confirming pair is a failure. A failure leads to a single reset command write of 0xF0 to the polled address, which returns the device to array reads. A parameter caps how many ordinary pairs may be spent before the block gives up and reports a timeout failure.

Top module: `tbit_poller`

## Requirements
- R1: After reset, busy_o, rd_req_o, wr_req_o, done_o, pass_o, fail_o and timeout_o are low and status_o is 0x00.
- R2: A start pulse while idle latches addr_i. Every read and write of the run uses that address, and every run makes at least two reads before it reaches a verdict.
- R3: When bit 6 of the two reads of a pair is equal, the run ends as a pass with no write issued. done_o and pass_o pulse in the cycle after the acknowledge of the second read.
- R4: When bit 6 differs and bit 5 of the second read of the pair is 0, another pair of reads follows.
- R5: When bit 6 differs and bit 5 of the second read is 1, exactly one confirming pair follows. If bit 6 is equal in that pair, the run is a pass.
- R6: If bit 6 differs in the confirming pair, a single write of 0xF0 to the latched address is issued. done_o and fail_o pulse in the cycle after its acknowledge, with timeout_o low.
- R7: If MAX_PAIRS ordinary pairs (confirming pairs not counted) all toggle with bit 5 low, the run fails with timeout_o raised together with fail_o, after the same 0xF0 write.
- R8: start_i and addr_i are ignored while busy_o is high.
- R9: done_o, pass_o, fail_o and timeout_o are single-cycle pulses. status_o carries the byte of the last read and holds it from done until the next accepted start, which clears it to 0x00.
- R10: rd_req_o and wr_req_o are never high together. Each request stays high until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (taken only when idle) |
| addr_i | input | AW | Address to poll |
| busy_o | output | 1 | A run is in progress |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, qualifies rd_data_i |
| rd_data_i | input | 8 | Read data |
| wr_req_o | output | 1 | Write request for the reset command |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | 8 | Write data |
| wr_ack_i | input | 1 | Write acknowledge |
| done_o | output | 1 | Run finished (pulse) |
| pass_o | output | 1 | Operation completed (pulse with done_o) |
| fail_o | output | 1 | Operation failed (pulse with done_o) |
| timeout_o | output | 1 | Failure caused by the pair limit (pulse with fail_o) |
| status_o | output | 8 | Last byte read |

## Verification
A wrong internal state would mostly appear as a wrong number of read cycles before done_o. The easiest cases to get wrong are a pair that straddles the device finishing, and an error bit that rises late. In those cases an extra confirming pair or a missing one changes the read count at once. A confused verdict would show as a write cycle on a pass, a missing write on a fail, or a timeout flag on the wrong pair. All of these appear at the ports within the same run, no later than the done pulse.

// File: rtl/tbit_pkg.sv
package tbit_pkg;
  localparam int TOG_BIT = 6;
  localparam int ERR_BIT = 5;
  localparam logic [7:0] RESET_CMD = 8'hF0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_WR_RST
  } st_e;

  typedef enum logic [1:0] {
    V_OK,
    V_AGAIN,
    V_RECHECK,
    V_FAIL
  } verdict_e;
endpackage

// File: rtl/tbit_pair_judge.sv
module tbit_pair_judge
  import tbit_pkg::*;
(
  input  logic     a_tog_i,
  input  logic     b_tog_i,
  input  logic     b_err_i,
  input  logic     recheck_i,
  input  logic     limit_hit_i,
  output verdict_e verdict_o,
  output logic     timeout_o
);
  always_comb begin
    timeout_o = 1'b0;
    if (a_tog_i == b_tog_i)  verdict_o = V_OK;
    else if (recheck_i)      verdict_o = V_FAIL;
    else if (b_err_i)        verdict_o = V_RECHECK;
    else if (limit_hit_i) begin
      verdict_o = V_FAIL;
      timeout_o = 1'b1;
    end
    else                     verdict_o = V_AGAIN;
  end
endmodule

// File: rtl/tbit_pair_ctr.sv
module tbit_pair_ctr #(
  parameter int MAX_PAIRS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1;
  localparam logic [CW-1:0] LAST = CW'(MAX_PAIRS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/tbit_fsm.sv
module tbit_fsm
  import tbit_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     rd_ack_i,
  input  logic     wr_ack_i,
  input  verdict_e verdict_i,
  input  logic     timeout_i,
  output st_e      state_o,
  output logic     recheck_o,
  output logic     launch_o,
  output logic     cap_a_o,
  output logic     cnt_inc_o,
  output logic     fin_pass_o,
  output logic     fin_fail_o,
  output logic     fin_tmo_o
);
  st_e  st_q, st_d;
  logic recheck_q, recheck_d;
  logic tmo_q, tmo_d;
  logic eval;

  assign eval = (st_q == ST_RD_B) && rd_ack_i;

  always_comb begin
    st_d      = st_q;
    recheck_d = recheck_q;
    tmo_d     = tmo_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d      = ST_RD_A;
        recheck_d = 1'b0;
        tmo_d     = 1'b0;
      end
      ST_RD_A: if (rd_ack_i) st_d = ST_RD_B;
      ST_RD_B: if (rd_ack_i) begin
        unique case (verdict_i)
          V_OK:      st_d = ST_IDLE;
          V_AGAIN:   st_d = ST_RD_A;
          V_RECHECK: begin
            st_d      = ST_RD_A;
            recheck_d = 1'b1;
          end
          V_FAIL: begin
            st_d  = ST_WR_RST;
            tmo_d = timeout_i;
          end
          default:   st_d = ST_IDLE;
        endcase
      end
      ST_WR_RST: if (wr_ack_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      recheck_q <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      recheck_q <= recheck_d;
      tmo_q     <= tmo_d;
    end
  end

  assign state_o    = st_q;
  assign recheck_o  = recheck_q;
  assign launch_o   = (st_q == ST_IDLE) && start_i;
  assign cap_a_o    = (st_q == ST_RD_A) && rd_ack_i;
  assign cnt_inc_o  = eval && (verdict_i == V_AGAIN);
  assign fin_pass_o = eval && (verdict_i == V_OK);
  assign fin_fail_o = (st_q == ST_WR_RST) && wr_ack_i;
  assign fin_tmo_o  = fin_fail_o && tmo_q;
endmodule

// File: rtl/tbit_poller.sv
module tbit_poller
  import tbit_pkg::*;
#(
  parameter int AW        = 19,
  parameter int MAX_PAIRS = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [7:0]    rd_data_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  input  logic          wr_ack_i,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic          timeout_o,
  output logic [7:0]    status_o
);
  st_e      state;
  verdict_e verdict;
  logic     recheck, launch, cap_a, cnt_inc, limit_hit, judge_tmo;
  logic     fin_pass, fin_fail, fin_tmo;
  logic [AW-1:0] addr_q;
  logic     a_tog_q;
  logic [7:0] status_q;
  logic     done_q, pass_q, fail_q, tmo_q;

  tbit_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .rd_ack_i   (rd_ack_i),
    .wr_ack_i   (wr_ack_i),
    .verdict_i  (verdict),
    .timeout_i  (judge_tmo),
    .state_o    (state),
    .recheck_o  (recheck),
    .launch_o   (launch),
    .cap_a_o    (cap_a),
    .cnt_inc_o  (cnt_inc),
    .fin_pass_o (fin_pass),
    .fin_fail_o (fin_fail),
    .fin_tmo_o  (fin_tmo)
  );

  tbit_pair_judge u_judge (
    .a_tog_i     (a_tog_q),
    .b_tog_i     (rd_data_i[TOG_BIT]),
    .b_err_i     (rd_data_i[ERR_BIT]),
    .recheck_i   (recheck),
    .limit_hit_i (limit_hit),
    .verdict_o   (verdict),
    .timeout_o   (judge_tmo)
  );

  tbit_pair_ctr #(.MAX_PAIRS(MAX_PAIRS)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (launch),
    .inc_i  (cnt_inc),
    .last_o (limit_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      a_tog_q  <= 1'b0;
      status_q <= '0;
    end else begin
      if (launch) addr_q <= addr_i;
      if (cap_a)  a_tog_q <= rd_data_i[TOG_BIT];
      if (launch)        status_q <= '0;
      else if (rd_req_o && rd_ack_i) status_q <= rd_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      done_q <= fin_pass | fin_fail;
      pass_q <= fin_pass;
      fail_q <= fin_fail;
      tmo_q  <= fin_tmo;
    end
  end

  assign busy_o    = (state != ST_IDLE);
  assign rd_req_o  = (state == ST_RD_A) || (state == ST_RD_B);
  assign wr_req_o  = (state == ST_WR_RST);
  assign rd_addr_o = addr_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = RESET_CMD;
  assign done_o    = done_q;
  assign pass_o    = pass_q;
  assign fail_o    = fail_q;
  assign timeout_o = tmo_q;
  assign status_o  = status_q;
endmodule

// File: rtl/tbit_poller_chk.sv
module tbit_poller_chk #(
  parameter int AW = 19
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ack_i,
  input logic          wr_req_o,
  input logic          wr_ack_i,
  input logic          done_o,
  input logic          pass_o,
  input logic          fail_o,
  input logic          timeout_o,
  input logic [7:0]    status_o
);
  p_req_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));
  p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o);
  p_wr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i |=> wr_req_o);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_one_verdict_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({pass_o, fail_o}) == 1);
  p_no_stray_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(pass_o || fail_o || timeout_o));
  p_status_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && $past(!busy_o && !start_i) |-> $stable(status_o));
  p_tmo_is_fail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> fail_o);
  p_fail_after_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> $past(wr_req_o && wr_ack_i));
  p_pass_after_rd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> $past(rd_req_o && rd_ack_i) && !$past(wr_req_o));
  p_addr_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(rd_addr_o));
endmodule

bind tbit_poller tbit_poller_chk #(.AW(AW)) u_chk (.*);

// File: tb/tbit_poller_bench.sv
module tbit_poller_bench;
  localparam int AW   = 8;
  localparam int MAXP = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          busy_o, rd_req_o, wr_req_o;
  logic [AW-1:0] rd_addr_o, wr_addr_o;
  logic          rd_ack_i = 1'b0;
  logic [7:0]    rd_data_i = '0;
  logic [7:0]    wr_data_o;
  logic          wr_ack_i = 1'b0;
  logic          done_o, pass_o, fail_o, timeout_o;
  logic [7:0]    status_o;

  always #2.5 clk_i = ~clk_i;

  tbit_poller #(.AW(AW), .MAX_PAIRS(MAXP)) u_tbit_poller (.*);

  int checks = 0, failures = 0;
  int cur_t = 0, cur_d = 0, lat = 0;
  int rd_cnt = 0, wr_cnt = 0, bad_addr = 0, rd_w = 0, wr_w = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [7:0] wr_seen = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d d=%0d)", req, act, exp, cur_t, cur_d);
    end
  endtask

  // device: busy for t reads (bit 6 alternates, bit 5 set from read d on), then array byte 0x3C
  function automatic logic [7:0] dev_val(int r, int t, int d);
    if (r < t) return {1'b1, r[0], (r >= d), 1'b0, r[3:0]};
    return 8'h3C;
  endfunction

  task automatic ref_run(input int t, input int d, output bit p, output bit tmo,
                         output int reads, output logic [7:0] st);
    int pairs = 0;
    bit rech = 0;
    logic [7:0] a, b;
    reads = 0; p = 0; tmo = 0; st = 0;
    forever begin
      a = dev_val(reads, t, d);
      b = dev_val(reads + 1, t, d);
      reads += 2;
      st = b;
      if (a[6] == b[6]) begin p = 1; break; end
      else if (rech) break;
      else if (b[5]) rech = 1;
      else begin
        pairs++;
        if (pairs == MAXP) begin tmo = 1; break; end
      end
    end
  endtask

  always @(negedge clk_i) begin
    if (rd_ack_i) rd_ack_i = 1'b0;
    else if (rd_req_o) begin
      if (rd_w >= lat) begin
        rd_ack_i  = 1'b1;
        rd_data_i = dev_val(rd_cnt, cur_t, cur_d);
        if (rd_addr_o != exp_addr) bad_addr++;
        rd_cnt++;
        rd_w = 0;
      end else rd_w++;
    end
    if (wr_ack_i) wr_ack_i = 1'b0;
    else if (wr_req_o) begin
      if (wr_w >= lat) begin
        wr_ack_i = 1'b1;
        wr_seen  = wr_data_o;
        if (wr_addr_o != exp_addr) bad_addr++;
        wr_cnt++;
        wr_w = 0;
      end else wr_w++;
    end
  end

  task automatic run_case(input int t, input int d, input int l, input logic [AW-1:0] a);
    bit ep, etmo; int ereads; logic [7:0] est; int n;
    ref_run(t, d, ep, etmo, ereads, est);
    @(negedge clk_i);
    cur_t = t; cur_d = d; lat = l; exp_addr = a;
    rd_cnt = 0; wr_cnt = 0; bad_addr = 0; rd_w = 0; wr_w = 0;
    start_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    addr_i = ~a;             // second start while busy
    check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    @(negedge clk_i);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 500) begin @(negedge clk_i); n++; end
    check(n < 500, "R3 run completes", n, 0);
    check(pass_o == ep, "R3/R5 pass verdict", pass_o, ep);
    check(fail_o == !ep, "R6 fail verdict", fail_o, !ep);
    check(timeout_o == etmo, "R7 timeout flag", timeout_o, etmo);
    check(rd_cnt == ereads, "R4/R5 read count", rd_cnt, ereads);
    check(rd_cnt >= 2, "R2 minimum two reads", rd_cnt, 2);
    check(status_o == est, "R9 status byte", status_o, est);
    check(wr_cnt == (ep ? 0 : 1), "R6 reset write count", wr_cnt, ep ? 0 : 1);
    if (!ep) check(wr_seen == 8'hF0, "R6 reset write data", wr_seen, 8'hF0);
    check(bad_addr == 0, "R8 start ignored while busy", bad_addr, 0);
    check(busy_o == 1'b0, "R9 idle at done", busy_o, 0);
    @(negedge clk_i);
    check(!done_o && !pass_o && !fail_o && !timeout_o, "R9 single-cycle pulse",
          {done_o, pass_o, fail_o, timeout_o}, 0);
    check(status_o == est, "R9 status held", status_o, est);
    check(!rd_req_o && !wr_req_o, "R10 no request after done", {rd_req_o, wr_req_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(!busy_o && !rd_req_o && !wr_req_o && !done_o && !pass_o && !fail_o && !timeout_o,
          "R1 reset outputs", {busy_o, rd_req_o, wr_req_o, done_o}, 0);
    check(status_o == 8'h00, "R1 reset status", status_o, 0);
    rst_ni = 1'b1;
    for (int t = 0; t < 12; t++)
      for (int d = 0; d <= 12; d++)
        run_case(t, d, (t + d) % 3, AW'(8'h11 * (t + 1) + d));
    // start clears the held status to 0x00
    @(negedge clk_i);
    cur_t = 20; cur_d = 20; lat = 3;
    start_i = 1'b1; addr_i = 8'h5A; exp_addr = 8'h5A; rd_cnt = 0;
    @(negedge clk_i);
    start_i = 1'b0;
    check(status_o == 8'h00, "R9 status cleared by start", status_o, 0);
    while (!done_o) @(negedge clk_i);
    check(timeout_o == 1'b1, "R7 timeout on long busy", timeout_o, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog expired R3 actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule